// File: doc/BRIEF.md
# Serial Flash Geometry Identifier

After reset this block works out which serial flash sits on its port and reports the flash geometry: the number of pages, the bytes per page, and how far a page number is shifted left to form a device address. It then raises a one-cycle completion pulse and holds the result until the next reset. Downstream read, program and erase logic uses these outputs to size its addresses.

The probe has two stages. First it issues an identity read and collects three response bytes. If the maker byte is recognised, the 24-bit identity is looked up in a fixed table. For parts that offer both a binary and a non-binary page layout, a status read then chooses between the two. If the maker byte is not recognised, the block reads the status byte and decodes a density code held in status bits 5:2. The block drives a byte-wide transfer engine through a request/acknowledge handshake and controls chip select itself. Every command and its response sit inside one chip-select frame, and chip select stays high for at least `CS_GAP` cycles between frames.

Top module: `flash_geom_probe`

## Requirements
- R1: While reset is held, `cs_n` is 1 and `xfer_req`, `done`, `found` and `absent` are 0.
- R2: The first frame carries the identity opcode 0x9F followed by three read bytes, each sent as dummy 0x00. The three returned bytes form a 24-bit identity, with the first byte in bits 23:16.
- R3: If the identity is a dual-layout part, a second frame is sent with the status opcode 0xD7 and one read byte. Status bit 0 = 1 selects the binary page (2^s bytes, shift s). Status bit 0 = 0 selects 2^s + 2^(s-5) bytes with shift s+1. The dual-layout parts are 0x1F2200 (512 pages, s=8), 0x1F2300 (1024, s=8), 0x1F2400 (2048, s=8), 0x1F2500 (4096, s=8), 0x1F2600 (4096, s=9), 0x1F2701 (8192, s=9) and 0x1F2800 (8192, s=10).
- R4: Identity 0x1F2700 reports 8192 pages of 528 bytes with shift 10 and sends no status frame.
- R5: A maker byte of 0x1F with an identity not listed in R3 or R4 gives `found`=0 and `absent`=0, with no status frame.
- R6: Any other maker byte leads to a status frame (0xD7 plus one read byte). The code in status bits 5:2 then decodes as follows: 3 → 512×264, 5 → 1024×264, 7 → 2048×264, 9 → 4096×264 (all shift 9); 11 → 4096×528 and 13 → 8192×528 (shift 10); 14 or 15 → 8192×1056 (shift 11).
- R7: On the fallback path, a status byte of 0x00 or 0xFF gives `absent`=1 and `found`=0.
- R8: On the fallback path, any other density code gives `found`=0 and `absent`=0.
- R9: `xfer_req` is asserted only while `cs_n` is 0. Between frames, `cs_n` stays high for at least `CS_GAP` cycles.
- R10: `done` pulses for exactly one cycle per reset. After it, all result outputs hold their values. While `found` is 0, `page_count`, `page_size` and `page_shift` are 0.
- R11: Once raised, `xfer_req` stays high until a cycle with `xfer_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; a new probe starts on release |
| cs_n | output | 1 | Flash chip select, active low |
| xfer_req | output | 1 | Byte transfer request to the byte engine |
| xfer_txd | output | 8 | Byte to shift out |
| xfer_ack | input | 1 | One-cycle pulse: byte exchanged, `xfer_rxd` valid |
| xfer_rxd | input | 8 | Byte shifted in |
| done | output | 1 | One-cycle pulse when identification ends |
| found | output | 1 | Geometry outputs are valid |
| absent | output | 1 | No device answered on the fallback path |
| page_count | output | 14 | Number of pages |
| page_size | output | 11 | Bytes per page |
| page_shift | output | 4 | Page-number shift within a device address |

## Verification
The checker enforces the framing rules on every cycle: a request only inside a chip-select frame, the minimum chip-select gap, and the request holding until acknowledge. It also enforces the single done pulse, the frozen results after it, zeroed geometry without a result, and the size/shift relation of any reported page. Only the bench scenarios can show that the right frames carry the right opcodes and dummies. The same goes for choosing the layout from status bit 0, the single-layout and unknown-identity cases, and the fallback density, empty-bus and unsupported-code decodes. These scenarios compare against values the bench derives for each identity and status pattern.

// File: rtl/flash_geom_pkg.sv
`timescale 1ns/1ps
package flash_geom_pkg;
    localparam int MAX_LG_PAGES = 13;
    localparam int MAX_BSHIFT   = 10;
    localparam int PG_W = MAX_LG_PAGES + 1;
    localparam int SZ_W = MAX_BSHIFT + 1;
    localparam int SH_W = $clog2(MAX_BSHIFT + 2);

    localparam logic [7:0] OP_IDENT  = 8'h9F;
    localparam logic [7:0] OP_STATUS = 8'hD7;
    localparam logic [7:0] DUMMY     = 8'h00;
    localparam logic [7:0] MAKER     = 8'h1F;

    typedef enum logic [2:0] {
        S_BOOT, S_ID, S_ID_EVAL, S_GAP, S_ST, S_ST_EVAL, S_DONE
    } probe_state_t;

    typedef struct packed {
        logic       hit;
        logic       dual;
        logic [3:0] lg_pages;
        logic [3:0] bshift;
    } geom_ent_t;
endpackage

// File: rtl/fgp_id_lookup.sv
`timescale 1ns/1ps
module fgp_id_lookup
    import flash_geom_pkg::*;
(
    input  logic [23:0] ident,
    output geom_ent_t   ent
);
    always_comb begin
        ent = '0;
        ent.hit = 1'b1;
        ent.dual = 1'b1;
        case (ident)
            24'h1F2200: begin ent.lg_pages = 4'd9;  ent.bshift = 4'd8;  end
            24'h1F2300: begin ent.lg_pages = 4'd10; ent.bshift = 4'd8;  end
            24'h1F2400: begin ent.lg_pages = 4'd11; ent.bshift = 4'd8;  end
            24'h1F2500: begin ent.lg_pages = 4'd12; ent.bshift = 4'd8;  end
            24'h1F2600: begin ent.lg_pages = 4'd12; ent.bshift = 4'd9;  end
            24'h1F2700: begin ent.lg_pages = 4'd13; ent.bshift = 4'd9; ent.dual = 1'b0; end
            24'h1F2701: begin ent.lg_pages = 4'd13; ent.bshift = 4'd9;  end
            24'h1F2800: begin ent.lg_pages = 4'd13; ent.bshift = 4'd10; end
            default:    begin ent.hit = 1'b0; ent.dual = 1'b0; end
        endcase
    end
endmodule

// File: rtl/fgp_density_decode.sv
`timescale 1ns/1ps
module fgp_density_decode
    import flash_geom_pkg::*;
(
    input  logic [7:0] status,
    output geom_ent_t  ent
);
    always_comb begin
        ent = '0;
        ent.hit = 1'b1;
        case (status[5:2])
            4'h3:       begin ent.lg_pages = 4'd9;  ent.bshift = 4'd8;  end
            4'h5:       begin ent.lg_pages = 4'd10; ent.bshift = 4'd8;  end
            4'h7:       begin ent.lg_pages = 4'd11; ent.bshift = 4'd8;  end
            4'h9:       begin ent.lg_pages = 4'd12; ent.bshift = 4'd8;  end
            4'hB:       begin ent.lg_pages = 4'd12; ent.bshift = 4'd9;  end
            4'hD:       begin ent.lg_pages = 4'd13; ent.bshift = 4'd9;  end
            4'hE, 4'hF: begin ent.lg_pages = 4'd13; ent.bshift = 4'd10; end
            default:    ent.hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/fgp_geom_build.sv
`timescale 1ns/1ps
module fgp_geom_build
    import flash_geom_pkg::*;
(
    input  logic [3:0]      lg_pages,
    input  logic [3:0]      bshift,
    input  logic            binary,
    output logic [PG_W-1:0] pages,
    output logic [SZ_W-1:0] size,
    output logic [SH_W-1:0] shift
);
    logic [SZ_W-1:0] base;

    always_comb begin
        pages = PG_W'(1) << lg_pages;
        base  = SZ_W'(1) << bshift;
        size  = binary ? base : base + (base >> 5);
        shift = binary ? SH_W'(bshift) : SH_W'(bshift) + SH_W'(1);
    end
endmodule

// File: rtl/flash_geom_probe.sv
`timescale 1ns/1ps
module flash_geom_probe
    import flash_geom_pkg::*;
#(
    parameter int CS_GAP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            cs_n,
    output logic            xfer_req,
    output logic [7:0]      xfer_txd,
    input  logic            xfer_ack,
    input  logic [7:0]      xfer_rxd,
    output logic            done,
    output logic            found,
    output logic            absent,
    output logic [PG_W-1:0] page_count,
    output logic [SZ_W-1:0] page_size,
    output logic [SH_W-1:0] page_shift
);
    localparam int GAP_W   = $clog2(CS_GAP + 1);
    localparam int ID_LAST = 3;
    localparam int ST_LAST = 1;

    typedef struct packed {
        probe_state_t    st;
        logic            cs_n;
        logic            req;
        logic [7:0]      txd;
        logic [1:0]      idx;
        logic [23:0]     ident;
        logic [7:0]      status;
        logic            use_id;
        logic [GAP_W-1:0] gap;
        logic            done;
        logic            found;
        logic            absent;
        logic [PG_W-1:0] pages;
        logic [SZ_W-1:0] size;
        logic [SH_W-1:0] shift;
    } probe_regs_t;

    probe_regs_t q, d;
    geom_ent_t   id_ent, dens_ent, pick_ent;
    logic        pick_binary;
    logic [PG_W-1:0] b_pages;
    logic [SZ_W-1:0] b_size;
    logic [SH_W-1:0] b_shift;

    fgp_id_lookup u_lookup (
        .ident (q.ident),
        .ent   (id_ent)
    );

    fgp_density_decode u_density (
        .status (q.status),
        .ent    (dens_ent)
    );

    always_comb begin
        if (q.st == S_ST_EVAL && !q.use_id) begin
            pick_ent    = dens_ent;
            pick_binary = 1'b0;
        end else begin
            pick_ent    = id_ent;
            pick_binary = (q.st == S_ST_EVAL) && q.status[0];
        end
    end

    fgp_geom_build u_build (
        .lg_pages (pick_ent.lg_pages),
        .bshift   (pick_ent.bshift),
        .binary   (pick_binary),
        .pages    (b_pages),
        .size     (b_size),
        .shift    (b_shift)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            S_BOOT: begin
                d.st   = S_ID;
                d.cs_n = 1'b0;
                d.idx  = '0;
            end
            S_ID: begin
                if (!q.req) begin
                    d.req = 1'b1;
                    d.txd = (q.idx == 2'd0) ? OP_IDENT : DUMMY;
                end else if (xfer_ack) begin
                    d.req = 1'b0;
                    if (q.idx != 2'd0) d.ident = {q.ident[15:0], xfer_rxd};
                    if (q.idx == 2'(ID_LAST)) begin
                        d.cs_n = 1'b1;
                        d.st   = S_ID_EVAL;
                    end else begin
                        d.idx = q.idx + 2'd1;
                    end
                end
            end
            S_ID_EVAL: begin
                d.gap = '0;
                if (q.ident[23:16] == MAKER) begin
                    d.use_id = 1'b1;
                    if (id_ent.hit && id_ent.dual) begin
                        d.st = S_GAP;
                    end else begin
                        d.st    = S_DONE;
                        d.done  = 1'b1;
                        d.found = id_ent.hit;
                        if (id_ent.hit) begin
                            d.pages = b_pages;
                            d.size  = b_size;
                            d.shift = b_shift;
                        end
                    end
                end else begin
                    d.use_id = 1'b0;
                    d.st     = S_GAP;
                end
            end
            S_GAP: begin
                if (q.gap == GAP_W'(CS_GAP - 1)) begin
                    d.st   = S_ST;
                    d.cs_n = 1'b0;
                    d.idx  = '0;
                end else begin
                    d.gap = q.gap + GAP_W'(1);
                end
            end
            S_ST: begin
                if (!q.req) begin
                    d.req = 1'b1;
                    d.txd = (q.idx == 2'd0) ? OP_STATUS : DUMMY;
                end else if (xfer_ack) begin
                    d.req = 1'b0;
                    if (q.idx == 2'(ST_LAST)) begin
                        d.status = xfer_rxd;
                        d.cs_n   = 1'b1;
                        d.st     = S_ST_EVAL;
                    end else begin
                        d.idx = q.idx + 2'd1;
                    end
                end
            end
            S_ST_EVAL: begin
                d.st   = S_DONE;
                d.done = 1'b1;
                if (!q.use_id && (q.status == 8'h00 || q.status == 8'hFF)) begin
                    d.absent = 1'b1;
                end else if (pick_ent.hit) begin
                    d.found = 1'b1;
                    d.pages = b_pages;
                    d.size  = b_size;
                    d.shift = b_shift;
                end
            end
            default: d.st = S_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_BOOT;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_n       = q.cs_n;
    assign xfer_req   = q.req;
    assign xfer_txd   = q.txd;
    assign done       = q.done;
    assign found      = q.found;
    assign absent     = q.absent;
    assign page_count = q.pages;
    assign page_size  = q.size;
    assign page_shift = q.shift;
endmodule

// File: rtl/fgp_checker.sv
`timescale 1ns/1ps
module fgp_checker
    import flash_geom_pkg::*;
#(
    parameter int CS_GAP = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            xfer_req,
    input logic            xfer_ack,
    input logic            done,
    input logic            found,
    input logic            absent,
    input logic [PG_W-1:0] page_count,
    input logic [SZ_W-1:0] page_size,
    input logic [SH_W-1:0] page_shift
);
    localparam int HC_W = $clog2(CS_GAP + 1);

    logic [HC_W-1:0] hi_cnt;
    logic            done_seen;
    logic [15:0]     lim_hi, lim_lo, sz_ext;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt    <= HC_W'(CS_GAP);
            done_seen <= 1'b0;
        end else begin
            if (!cs_n)                      hi_cnt <= '0;
            else if (hi_cnt != HC_W'(CS_GAP)) hi_cnt <= hi_cnt + HC_W'(1);
            if (done) done_seen <= 1'b1;
        end
    end

    always_comb begin
        lim_hi = 16'd1 << page_shift;
        lim_lo = 16'd1 << (page_shift - SH_W'(1));
        sz_ext = 16'(page_size);
    end

    p_req_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !cs_n);
    p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> hi_cnt >= HC_W'(CS_GAP));
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> xfer_req);
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_seen |-> !done);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_seen |-> ($stable(found) && $stable(absent) && $stable(page_count)
                       && $stable(page_size) && $stable(page_shift)));
    p_zero_geom_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !found |-> (page_count == '0 && page_size == '0 && page_shift == '0));
    p_absent_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(found && absent));
    p_size_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (sz_ext <= lim_hi && sz_ext > lim_lo));
endmodule

bind flash_geom_probe fgp_checker #(.CS_GAP(CS_GAP)) u_fgp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .xfer_req   (xfer_req),
    .xfer_ack   (xfer_ack),
    .done       (done),
    .found      (found),
    .absent     (absent),
    .page_count (page_count),
    .page_size  (page_size),
    .page_shift (page_shift)
);

// File: tb/flash_geom_probe_test.sv
`timescale 1ns/1ps
module flash_geom_probe_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n, xfer_req, done, found, absent;
    logic [7:0]  xfer_txd;
    logic        xfer_ack = 1'b0;
    logic [7:0]  xfer_rxd = 8'h00;
    logic [13:0] page_count;
    logic [10:0] page_size;
    logic [3:0]  page_shift;

    always #2 clk = ~clk;

    flash_geom_probe #(.CS_GAP(4)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .xfer_req(xfer_req),
        .xfer_txd(xfer_txd), .xfer_ack(xfer_ack), .xfer_rxd(xfer_rxd),
        .done(done), .found(found), .absent(absent),
        .page_count(page_count), .page_size(page_size), .page_shift(page_shift)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] m_id [3];
    logic [7:0] m_st;
    int lat = 1;
    int frames, bif, stray, dummy_bad, done_cnt;
    logic [7:0] f_op [4];
    int f_len [4];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial forever begin
        @(negedge cs_n);
        frames++;
        bif = 0;
    end

    initial forever begin
        @(negedge clk);
        if (done === 1'b1) done_cnt++;
    end

    initial forever begin
        logic [7:0] rx;
        @(negedge clk);
        if (xfer_req === 1'b1) begin
            repeat (lat) @(negedge clk);
            rx = 8'h00;
            if (cs_n !== 1'b0 || frames < 1 || frames > 4) begin
                stray++;
            end else begin
                if (bif == 0) f_op[frames-1] = xfer_txd;
                else if (xfer_txd !== 8'h00) dummy_bad++;
                if (f_op[frames-1] == 8'h9F && bif >= 1 && bif <= 3) rx = m_id[bif-1];
                if (f_op[frames-1] == 8'hD7 && bif >= 1) rx = m_st;
                f_len[frames-1]++;
            end
            bif++;
            xfer_rxd = rx;
            xfer_ack = 1'b1;
            @(negedge clk);
            xfer_ack = 1'b0;
        end
    end

    // Expected result derived from the requirement tables
    task automatic expect_of(input logic [7:0] m, d1, d2, st,
                             output logic e_found, output logic e_absent,
                             output int e_pages, output int e_size,
                             output int e_shift, output int e_frames);
        int bsz;
        bit dual;
        e_found = 0; e_absent = 0; e_pages = 0; e_size = 0; e_shift = 0;
        if (m == 8'h1F) begin
            bsz = 0; dual = 1;
            case ({d1, d2})
                16'h2200: begin e_pages = 512;  bsz = 256;  end
                16'h2300: begin e_pages = 1024; bsz = 256;  end
                16'h2400: begin e_pages = 2048; bsz = 256;  end
                16'h2500: begin e_pages = 4096; bsz = 256;  end
                16'h2600: begin e_pages = 4096; bsz = 512;  end
                16'h2701: begin e_pages = 8192; bsz = 512;  end
                16'h2800: begin e_pages = 8192; bsz = 1024; end
                16'h2700: begin e_pages = 8192; bsz = 528; dual = 0; end
                default:  begin e_pages = 0; dual = 0; end
            endcase
            if (e_pages == 0) begin
                e_frames = 1;
            end else if (!dual) begin
                e_found = 1; e_size = 528; e_shift = 10; e_frames = 1;
            end else begin
                e_found = 1; e_frames = 2;
                if (st[0]) begin e_size = bsz; e_shift = $clog2(bsz); end
                else begin e_size = bsz + bsz / 32; e_shift = $clog2(bsz) + 1; end
            end
        end else begin
            e_frames = 2;
            if (st == 8'h00 || st == 8'hFF) begin
                e_absent = 1;
            end else begin
                e_found = 1;
                case (st & 8'h3C)
                    8'h0C: begin e_pages = 512;  e_size = 264;  e_shift = 9;  end
                    8'h14: begin e_pages = 1024; e_size = 264;  e_shift = 9;  end
                    8'h1C: begin e_pages = 2048; e_size = 264;  e_shift = 9;  end
                    8'h24: begin e_pages = 4096; e_size = 264;  e_shift = 9;  end
                    8'h2C: begin e_pages = 4096; e_size = 528;  e_shift = 10; end
                    8'h34: begin e_pages = 8192; e_size = 528;  e_shift = 10; end
                    8'h38, 8'h3C: begin e_pages = 8192; e_size = 1056; e_shift = 11; end
                    default: e_found = 0;
                endcase
            end
        end
    endtask

    task automatic run_case(input logic [7:0] m, d1, d2, st, input string tag);
        logic e_found, e_absent;
        int e_pages, e_size, e_shift, e_frames, wait_n;
        expect_of(m, d1, d2, st, e_found, e_absent, e_pages, e_size, e_shift, e_frames);
        m_id[0] = m; m_id[1] = d1; m_id[2] = d2; m_st = st;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        frames = 0; bif = 0; stray = 0; dummy_bad = 0; done_cnt = 0;
        for (int i = 0; i < 4; i++) begin f_op[i] = 8'h00; f_len[i] = 0; end
        check({"R1 reset outputs ", tag}, {cs_n, xfer_req, done, found, absent}, 5'b10000);
        rst_n = 1'b1;
        wait_n = 0;
        while (done !== 1'b1 && wait_n < 400) begin
            @(negedge clk);
            wait_n++;
        end
        repeat (4) @(negedge clk);
        check({"R10 single done ", tag}, done_cnt, 1);
        check({"R2 id opcode ", tag}, f_op[0], 8'h9F);
        check({"R2 id frame length ", tag}, f_len[0], 4);
        check({"R2 dummy bytes ", tag}, dummy_bad, 0);
        check({"R9 no byte outside frame ", tag}, stray, 0);
        check({"R5 frame count ", tag}, frames, e_frames);
        if (e_frames == 2) begin
            check({"R3 status opcode ", tag}, f_op[1], 8'hD7);
            check({"R6 status frame length ", tag}, f_len[1], 2);
        end
        check({"R7 absent flag ", tag}, absent, e_absent);
        check({"R8 found flag ", tag}, found, e_found);
        check({"R3 page count ", tag}, page_count, e_pages);
        check({"R4 page size ", tag}, page_size, e_size);
        check({"R6 page shift ", tag}, page_shift, e_shift);
    endtask

    initial begin
        logic [7:0] ids [8][2];
        ids = '{'{8'h22,8'h00}, '{8'h23,8'h00}, '{8'h24,8'h00}, '{8'h25,8'h00},
                '{8'h26,8'h00}, '{8'h27,8'h01}, '{8'h28,8'h00}, '{8'h27,8'h00}};
        void'($urandom(32'd1234));
        // R3: dual-layout parts, both layouts
        for (int i = 0; i < 7; i++) begin
            run_case(8'h1F, ids[i][0], ids[i][1], 8'h81, "R3 binary");
            run_case(8'h1F, ids[i][0], ids[i][1], 8'h80, "R3 nonbinary");
        end
        run_case(8'h1F, 8'h27, 8'h00, 8'h81, "R4 single layout");
        run_case(8'h1F, 8'h29, 8'h00, 8'h81, "R5 unknown id");
        run_case(8'h1F, 8'h27, 8'h02, 8'h80, "R5 unknown id");
        // R6: fallback density codes
        for (int c = 0; c < 16; c++)
            run_case(8'h00, 8'h00, 8'h00, 8'h80 | 8'(c << 2), "R6 density");
        run_case(8'h7E, 8'h11, 8'h22, 8'h00, "R7 empty 00");
        run_case(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R7 empty FF");
        run_case(8'h00, 8'h00, 8'h00, 8'h90, "R8 unsupported code");
        // Random mix
        for (int n = 0; n < 60; n++) begin
            int kind, pick;
            logic [7:0] m;
            lat = 1 + int'($urandom % 3);
            kind = int'($urandom % 3);
            pick = int'($urandom % 8);
            m = 8'($urandom);
            if (m == 8'h1F) m = 8'h20;
            case (kind)
                0: run_case(8'h1F, ids[pick][0], ids[pick][1], 8'($urandom), "R3 random table");
                1: run_case(8'h1F, 8'($urandom), 8'($urandom), 8'($urandom), "R5 random id");
                default: run_case(m, 8'($urandom), 8'($urandom), 8'($urandom), "R6 random fallback");
            endcase
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog expired actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule